// File: doc/BRIEF.md
# PHY Strap-Pin Configuration Latch

This block captures a set of board-level strap inputs while reset is held and turns them into the power-up contents of a small bank of 16-bit PHY management registers. The straps are a 5-bit PHY address, two configuration pins, a full-duplex-enable pin and an auto-negotiation-enable pin. Once reset is released the straps are no longer looked at, and the registers belong to management writes.

The same address straps have two further jobs. First, they set the polarity of five LED drivers: a strap tied low gives an active-high LED, and a strap tied high gives an active-low LED. Second, an address of all zeros sets the isolate bit. The configuration straps decode into the four ability-advertisement bits. A plain register read and write port stands in for the serial management interface. The latched address and the isolate flag are brought out as pins.

Top module: `phy_strap_cfg`

## Requirements
- R1: While `rst_n` is low, every rising clock edge loads the register bank, the PHY address and the LED polarity from the current straps. Once `rst_n` is high, strap changes have no effect until the next reset.
- R2: `phy_addr` equals the address straps sampled at the last clock edge that saw `rst_n` low.
- R3: `led_out[i]` equals `led_raw[i]` XOR the sampled address strap bit `i`. A strap sampled low gives an active-high output, and one sampled high gives an active-low output.
- R4: Control register (address 0) bit 11 resets to 1 when the sampled address is 00000 and to 0 otherwise. `isolate` always shows the current control bit 11, including after writes.
- R5: Control register bit 12 resets to the auto-negotiation strap. All other control bits reset to 0.
- R6: Advertisement register (address 4) bits [8:5] are, from bit 8 down, 100-full, 100-half, 10-full and 10-half. With the auto-negotiation strap at 1, the value of {cfg0,cfg1,fde} selects them as follows: 111→1111, 100→0100, 101→1100, 010→0001, 011→0011, 110→0101.
- R7: Advertisement bits [8:5] reset to 1111 when the auto-negotiation strap is 0, or when cfg0 and cfg1 are both 0.
- R8: Advertisement bits [4:0] reset to 00001 and its other bits reset to 0. Registers 2 and 3 reset to the `ID1_RST` and `ID2_RST` parameters. Registers 1, 5, 6 and 16–19 reset to zero.
- R9: The registers live at addresses 0–6 and 16–19. A write with `mgmt_wr` high stores the full `mgmt_wdata` word at the next edge. `mgmt_rdata` shows the addressed register combinationally.
- R10: A write to any other address changes no register, and a read of such an address returns zero.
- R11: A control write that takes bit 12 from 1 to 0 also sets advertisement bits [8:5] to 1111 on the same edge. The other advertisement bits are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_addr | input | 5 | PHY address straps, also LED polarity |
| strap_cfg0 | input | 1 | Configuration strap 0 |
| strap_cfg1 | input | 1 | Configuration strap 1 |
| strap_fde | input | 1 | Full-duplex-enable strap |
| strap_ane | input | 1 | Auto-negotiation-enable strap |
| led_raw | input | 5 | Internal LED status, active-high |
| led_out | output | 5 | LED drivers after polarity |
| phy_addr | output | 5 | Latched PHY address |
| isolate | output | 1 | Control bit 11 |
| mgmt_wr | input | 1 | Register write strobe |
| mgmt_addr | input | 5 | Register address for reads and writes |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data of the addressed register |

## Verification
The bench resets the block under eight strap patterns. Each pattern targets a different path. One pattern uses each listed {cfg0,cfg1,fde} code, which tells the six advertisement encodings apart. The unlisted cfg0=cfg1=0 case and an auto-negotiation strap of 0 each fall back to 1111. An all-zero address separates the isolate path from non-zero addresses. Mixed address bits show a per-bit LED polarity rather than a global one. After each reset the straps are scrambled to show they are frozen. A write sequence then tells apart a mapped write, an unmapped write, a control write that keeps bit 12 set, and one that clears it.

// File: rtl/phy_strap_pkg.sv
package phy_strap_pkg;

    localparam int REG_W    = 16;
    localparam int ADDR_W   = 5;
    localparam int NUM_STD  = 7;
    localparam int NUM_VND  = 4;
    localparam int NUM_REGS = NUM_STD + NUM_VND;
    localparam int VND_BASE = 16;

    // slot indices of registers with special reset or write behaviour
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_ID1  = 2;
    localparam int SLOT_ID2  = 3;
    localparam int SLOT_ADV  = 4;

    localparam int CTRL_ANE_BIT = 12;
    localparam int CTRL_ISO_BIT = 11;
    localparam int ADV_ABIL_LO  = 5;
    localparam int ADV_ABIL_HI  = 8;
    localparam int ADV_SEL_W    = 5;
    localparam logic [ADV_SEL_W-1:0] ADV_SEL_RST = 5'b00001;

    typedef logic [REG_W-1:0] word_t;
    typedef logic [NUM_REGS-1:0][REG_W-1:0] regbank_t;

    // management address of a storage slot
    function automatic logic [ADDR_W-1:0] slot_addr(input int s);
        if (s < NUM_STD) return ADDR_W'(s);
        return ADDR_W'(VND_BASE + s - NUM_STD);
    endfunction

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
        return (int'(a) < NUM_STD) ||
               ((int'(a) >= VND_BASE) && (int'(a) < VND_BASE + NUM_VND));
    endfunction

    // ability bits {100FD,100HD,10FD,10HD} from straps
    function automatic logic [3:0] ability_decode(input logic c0, input logic c1,
                                                   input logic fde, input logic ane);
        logic [3:0] r;
        case ({c0, c1, fde})
            3'b111:  r = 4'b1111;
            3'b100:  r = 4'b0100;
            3'b101:  r = 4'b1100;
            3'b010:  r = 4'b0001;
            3'b011:  r = 4'b0011;
            3'b110:  r = 4'b0101;
            default: r = 4'b1111;
        endcase
        if (!ane) r = 4'b1111;
        return r;
    endfunction

endpackage

// File: rtl/phy_strap_decode.sv
module phy_strap_decode
    import phy_strap_pkg::*;
#(
    parameter word_t ID1_RST = 16'h0a1c,
    parameter word_t ID2_RST = 16'h5d20
) (
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              strap_cfg0,
    input  logic              strap_cfg1,
    input  logic              strap_fde,
    input  logic              strap_ane,
    output regbank_t          reset_img
);

    logic [3:0] abil;

    always_comb begin
        abil = ability_decode(strap_cfg0, strap_cfg1, strap_fde, strap_ane);
    end

    always_comb begin
        reset_img = '0;
        reset_img[SLOT_CTRL][CTRL_ANE_BIT] = strap_ane;
        reset_img[SLOT_CTRL][CTRL_ISO_BIT] = (strap_addr == '0);
        reset_img[SLOT_ID1] = ID1_RST;
        reset_img[SLOT_ID2] = ID2_RST;
        reset_img[SLOT_ADV][ADV_ABIL_HI:ADV_ABIL_LO] = abil;
        reset_img[SLOT_ADV][ADV_SEL_W-1:0] = ADV_SEL_RST;
    end

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  regbank_t          reset_img,
    input  logic              mgmt_wr,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  word_t             mgmt_wdata,
    output word_t             mgmt_rdata,
    output word_t             ctrl_word
);

    typedef struct packed {
        regbank_t bank;
    } rf_state_t;

    rf_state_t rf_d, rf_q;
    logic [NUM_REGS-1:0] hit;
    logic                ane_drop;

    genvar s;
    generate
        for (s = 0; s < NUM_REGS; s++) begin : g_hit
            assign hit[s] = (mgmt_addr == slot_addr(s));
        end
    endgenerate

    assign ane_drop = mgmt_wr && hit[SLOT_CTRL]
                   && rf_q.bank[SLOT_CTRL][CTRL_ANE_BIT]
                   && !mgmt_wdata[CTRL_ANE_BIT];

    always_comb begin
        rf_d = rf_q;
        if (!rst_n) begin
            rf_d.bank = reset_img;
        end else if (mgmt_wr) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (hit[i]) rf_d.bank[i] = mgmt_wdata;
            end
            if (ane_drop) rf_d.bank[SLOT_ADV][ADV_ABIL_HI:ADV_ABIL_LO] = 4'b1111;
        end
    end

    always_ff @(posedge clk) begin
        rf_q <= rf_d;
    end

    always_comb begin
        mgmt_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) mgmt_rdata = mgmt_rdata | rf_q.bank[i];
        end
    end

    assign ctrl_word = rf_q.bank[SLOT_CTRL];

endmodule

// File: rtl/phy_led_polarity.sv
module phy_led_polarity #(
    parameter int NUM_LED = 5
) (
    input  logic [NUM_LED-1:0] led_raw,
    input  logic [NUM_LED-1:0] pol,
    output logic [NUM_LED-1:0] led_out
);

    genvar i;
    generate
        for (i = 0; i < NUM_LED; i++) begin : g_led
            assign led_out[i] = led_raw[i] ^ pol[i];
        end
    endgenerate

endmodule

// File: rtl/phy_strap_cfg.sv
module phy_strap_cfg
    import phy_strap_pkg::*;
#(
    parameter word_t ID1_RST = 16'h0a1c,
    parameter word_t ID2_RST = 16'h5d20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              strap_cfg0,
    input  logic              strap_cfg1,
    input  logic              strap_fde,
    input  logic              strap_ane,
    input  logic [ADDR_W-1:0] led_raw,
    output logic [ADDR_W-1:0] led_out,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              isolate,
    input  logic              mgmt_wr,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic [REG_W-1:0]  mgmt_wdata,
    output logic [REG_W-1:0]  mgmt_rdata
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } top_state_t;

    top_state_t st_d, st_q;
    regbank_t   reset_img;
    word_t      ctrl_word;

    // address straps double as LED polarity; both frozen once reset ends
    always_comb begin
        st_d = st_q;
        if (!rst_n) st_d.addr = strap_addr;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    phy_strap_decode #(
        .ID1_RST (ID1_RST),
        .ID2_RST (ID2_RST)
    ) u_decode (
        .strap_addr (strap_addr),
        .strap_cfg0 (strap_cfg0),
        .strap_cfg1 (strap_cfg1),
        .strap_fde  (strap_fde),
        .strap_ane  (strap_ane),
        .reset_img  (reset_img)
    );

    phy_mgmt_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reset_img  (reset_img),
        .mgmt_wr    (mgmt_wr),
        .mgmt_addr  (mgmt_addr),
        .mgmt_wdata (mgmt_wdata),
        .mgmt_rdata (mgmt_rdata),
        .ctrl_word  (ctrl_word)
    );

    phy_led_polarity #(
        .NUM_LED (ADDR_W)
    ) u_led (
        .led_raw (led_raw),
        .pol     (st_q.addr),
        .led_out (led_out)
    );

    assign phy_addr = st_q.addr;
    assign isolate  = ctrl_word[CTRL_ISO_BIT];

endmodule

// File: rtl/phy_strap_cfg_chk.sv
module phy_strap_cfg_chk
    import phy_strap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] strap_addr,
    input logic [ADDR_W-1:0] led_raw,
    input logic [ADDR_W-1:0] led_out,
    input logic [ADDR_W-1:0] phy_addr,
    input logic              isolate,
    input logic              mgmt_wr,
    input logic [ADDR_W-1:0] mgmt_addr,
    input logic [REG_W-1:0]  mgmt_wdata,
    input logic [REG_W-1:0]  mgmt_rdata
);

    assert_straps_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(phy_addr));

    assert_addr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> phy_addr == $past(strap_addr));

    assert_led_polarity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        led_out == (led_raw ^ phy_addr));

    assert_isolate_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> isolate == ($past(strap_addr) == '0));

    assert_write_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && addr_mapped(mgmt_addr)) |=>
            ($stable(mgmt_addr) |-> mgmt_rdata == $past(mgmt_wdata)));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mapped(mgmt_addr) |-> mgmt_rdata == '0);

endmodule

bind phy_strap_cfg phy_strap_cfg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_addr (strap_addr),
    .led_raw    (led_raw),
    .led_out    (led_out),
    .phy_addr   (phy_addr),
    .isolate    (isolate),
    .mgmt_wr    (mgmt_wr),
    .mgmt_addr  (mgmt_addr),
    .mgmt_wdata (mgmt_wdata),
    .mgmt_rdata (mgmt_rdata)
);

// File: tb/sim_phy_strap_cfg.sv
`timescale 1ns/1ps
module sim_phy_strap_cfg;

    localparam logic [15:0] ID1 = 16'h0a1c;
    localparam logic [15:0] ID2 = 16'h5d20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_addr = '0;
    logic        strap_cfg0 = 1'b0, strap_cfg1 = 1'b0, strap_fde = 1'b0, strap_ane = 1'b0;
    logic [4:0]  led_raw = '0;
    logic [4:0]  led_out, phy_addr;
    logic        isolate;
    logic        mgmt_wr = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    logic [15:0] mregs [32];
    logic [4:0]  maddr = '0;

    always #5 clk = ~clk;

    phy_strap_cfg u0 (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
        .strap_cfg0(strap_cfg0), .strap_cfg1(strap_cfg1),
        .strap_fde(strap_fde), .strap_ane(strap_ane),
        .led_raw(led_raw), .led_out(led_out), .phy_addr(phy_addr),
        .isolate(isolate), .mgmt_wr(mgmt_wr), .mgmt_addr(mgmt_addr),
        .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata)
    );

    function automatic bit m_valid(input logic [4:0] a);
        return (a <= 5'd6) || (a >= 5'd16 && a <= 5'd19);
    endfunction

    function automatic logic [3:0] m_abil(input logic c0, c1, f, an);
        if (!an) return 4'hF;
        if (c0 && c1 && f)   return 4'b1111;
        if (c0 && !c1 && !f) return 4'b0100;
        if (c0 && !c1 && f)  return 4'b1100;
        if (!c0 && c1 && !f) return 4'b0001;
        if (!c0 && c1 && f)  return 4'b0011;
        if (c0 && c1 && !f)  return 4'b0101;
        return 4'hF;
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mregs[i] = '0;
            mregs[0][12] = strap_ane;
            mregs[0][11] = (strap_addr == 5'd0);
            mregs[2] = ID1;
            mregs[3] = ID2;
            mregs[4] = {7'd0, m_abil(strap_cfg0, strap_cfg1, strap_fde, strap_ane), 5'b00001};
            maddr = strap_addr;
        end else if (mgmt_wr && m_valid(mgmt_addr)) begin
            if (mgmt_addr == 5'd0 && mregs[0][12] && !mgmt_wdata[12])
                mregs[4][8:5] = 4'hF; // R11
            mregs[mgmt_addr] = mgmt_wdata;
        end
    endtask

    task automatic compare_all(input string rtag);
        chk("R2", {11'd0, phy_addr}, {11'd0, maddr});
        chk("R3", {11'd0, led_out}, {11'd0, led_raw ^ maddr});
        chk("R4", {15'd0, isolate}, {15'd0, mregs[0][11]});
        chk(rtag, mgmt_rdata, m_valid(mgmt_addr) ? mregs[mgmt_addr] : 16'h0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst_n) compare_all("R9");
        led_raw = led_raw * 5'd7 + 5'd3;
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        mgmt_addr = a;
        #1;
        chk(tag, mgmt_rdata, m_valid(a) ? mregs[a] : 16'h0);
    endtask

    task automatic rd_all();
        for (int a = 0; a < 32; a++) begin
            string t;
            if (a == 0)              t = "R5";
            else if (a == 4)         t = "R6";
            else if (!m_valid(5'(a))) t = "R10";
            else                     t = "R8";
            rd(5'(a), t);
        end
    endtask

    task automatic do_reset(input logic [4:0] ad, input logic c0, c1, f, an);
        strap_addr = ad; strap_cfg0 = c0; strap_cfg1 = c1; strap_fde = f; strap_ane = an;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        rd_all();
        // R1: scramble straps after release; nothing may follow them
        strap_addr = ~ad; strap_cfg0 = ~c0; strap_cfg1 = ~c1; strap_fde = ~f; strap_ane = ~an;
        tick(); tick();
        chk("R1", {11'd0, phy_addr}, {11'd0, maddr});
        rd(5'd0, "R1");
        rd(5'd4, "R1");
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        mgmt_addr = a; mgmt_wdata = d; mgmt_wr = 1'b1;
        tick();
        mgmt_wr = 1'b0;
    endtask

    initial begin
        // reset state with several strap patterns (R6 table, R7 fallbacks, R4 zero address)
        do_reset(5'h00, 1, 1, 1, 1);
        do_reset(5'h13, 1, 0, 0, 1);
        do_reset(5'h0a, 1, 0, 1, 1);
        do_reset(5'h1f, 0, 1, 0, 1);
        do_reset(5'h01, 0, 1, 1, 1);
        do_reset(5'h16, 1, 1, 0, 1);
        do_reset(5'h05, 0, 0, 1, 1);   // R7 cfg 00
        do_reset(5'h0c, 1, 0, 0, 0);   // R7 ane strap low
        // management traffic
        do_reset(5'h00, 0, 1, 0, 1);
        wr(5'd16, 16'hbeef); rd(5'd16, "R9");
        wr(5'd4,  16'h0123); rd(5'd4,  "R9");
        wr(5'd9,  16'hffff); rd(5'd9,  "R10"); rd_all();
        wr(5'd31, 16'h5a5a); rd_all();
        wr(5'd4,  16'h0021);
        wr(5'd0,  16'h1800); rd(5'd4, "R11");   // bit 12 kept: no change
        wr(5'd0,  16'h0800); rd(5'd4, "R11");   // bit 12 dropped: ability 1111
        chk("R11", mgmt_rdata, 16'h01e1);
        wr(5'd0,  16'h0000); rd(5'd0, "R4");
        chk("R4", {15'd0, isolate}, 16'd0);
        wr(5'd19, 16'h1234); rd_all();
        for (int k = 0; k < 10; k++) tick();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule